// File: doc/BRIEF.md
# Three-Stage Multi-Cycle Processor Core

This is a small 32-bit processor core. It executes one fixed-length instruction word at a time. Each instruction goes through three states of a control machine. In the fetch state the word at the program counter is read into an instruction register. In the decode state the fields are split, the three source registers are read and the effective address is formed. In the execute state the instruction takes effect and the result is written back. A single word-addressed memory port serves both instruction fetch and data access. Memory reads are combinational, and memory writes are strobed by a write enable.

The core has a 32-entry register file in which register 0 always reads zero. It has an adder/subtractor and an equality comparator. It runs six operations: load, store, add, subtract, jump and branch-if-equal. Any other encoding stops the core in a terminal state and raises `halt`, so a testbench can end a program by placing an undefined word after it.

The states are FETCH, DECODE, EXEC and HALT. The transitions are FETCH to DECODE, DECODE to EXEC for a legal word, DECODE to HALT for an illegal one, EXEC to FETCH, and HALT to itself. Reset returns the core to FETCH.

Top module: `mc_core`

## Requirements
- R1: Active-low reset sets the program counter to 0 and clears all 32 registers. While in reset, `mem_addr` is 0 and `halt` and `mem_we` are low.
- R2: Each legal instruction takes exactly three clock cycles: FETCH, DECODE, EXEC. If the program executes n legal instructions and then reaches an illegal word, `halt` is first high after 3n+2 rising edges following reset release.
- R3: An instruction word is laid out as opcode [31:26], first register A [25:20+1], second register B [20:16] and a 16-bit field K [15:0]. LOAD (opcode 000001) writes the memory word at the effective address into register A. A zero B field selects direct addressing, where the address is K. A nonzero B field selects indexed addressing, where the address is K plus register B.
- R4: STORE (opcode 000010) writes register A to the effective address, formed as in R3. `mem_we` is high for exactly that one EXEC cycle.
- R5: ADD (000011) writes B + C into register A, and SUB (000100) writes B - C into register A. C is the register numbered by K[4:0]. Both results wrap modulo 2^32.
- R6: JMP (000101) loads the program counter with K, and execution continues there.
- R7: BEQ (000110) compares registers A and B. When they are equal, the program counter becomes the already incremented program counter plus K, sign-extended. Otherwise execution falls through to the next word.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: An opcode outside 000001..000110, or an ADD/SUB with a nonzero K[15:5], sends the core to HALT. The instruction has no effect. In HALT, `halt` stays high until reset, `mem_we` stays low and `mem_addr` stays constant.
- R10: The program counter advances by one word at the end of every FETCH cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W (16) | Word address: program counter in FETCH/DECODE, effective address in EXEC |
| mem_rdata | input | DATA_W (32) | Combinational read data for `mem_addr` |
| mem_wdata | output | DATA_W (32) | Store data |
| mem_we | output | 1 | Write strobe for a store |
| halt | output | 1 | High while the core is in HALT |

## Verification
The bench goes after the following corner cases.

A backward branch is tested with a negative offset taken from the incremented program counter. A core that used the unincremented value, or zero-extended the offset, would loop a different number of times or run away.

A write to register 0 is tested. A core that let it through would store a nonzero value where zero is expected.

Direct and indexed addressing are run side by side. Mixing up the index register or the mode bit would place data at the wrong word.

An ADD with stray high bits in K, and opcodes 0, 7 and 63, are tested. These must stop the core without effect, with `halt` rising on the exact cycle that R2 predicts. A core that executed them, or halted a cycle late, would show in memory or in the halt timing.

Finally, a program that reads a register it never wrote is run after a reset. It checks that reset truly cleared the register file.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int RIDX_W  = 5;
    localparam int K_W     = 16;

    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int RA_LSB  = OPC_LSB - RIDX_W;
    localparam int RB_LSB  = RA_LSB - RIDX_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_SUB   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000110;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_LOAD,
        K_STORE,
        K_ADD,
        K_SUB,
        K_JMP,
        K_BEQ,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] rc;
        logic [K_W-1:0]    k;
        logic              indexed;
    } dec_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [INSN_W-1:0] ir,
    output dec_t              dec
);

    logic [OPC_W-1:0] opc;
    logic             k_hi_clean;

    assign opc        = ir[INSN_W-1:OPC_LSB];
    assign k_hi_clean = (ir[K_W-1:RIDX_W] == '0);

    always_comb begin
        dec.ra      = ir[OPC_LSB-1:RA_LSB];
        dec.rb      = ir[RA_LSB-1:RB_LSB];
        dec.k       = ir[K_W-1:0];
        dec.rc      = ir[RIDX_W-1:0];
        dec.indexed = (ir[RA_LSB-1:RB_LSB] != '0);
        unique case (opc)
            OPC_LOAD:  dec.kind = K_LOAD;
            OPC_STORE: dec.kind = K_STORE;
            OPC_ADD:   dec.kind = k_hi_clean ? K_ADD : K_BAD;
            OPC_SUB:   dec.kind = k_hi_clean ? K_SUB : K_BAD;
            OPC_JMP:   dec.kind = K_JMP;
            OPC_BEQ:   dec.kind = K_BEQ;
            default:   dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             wa,
    input  logic [WIDTH-1:0]          wd,
    input  logic [NRD-1:0][AW-1:0]    ra,
    output logic [NRD-1:0][WIDTH-1:0] rd
);

    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             sub,
    input  logic [WIDTH-1:0] cmp_a,
    input  logic [WIDTH-1:0] cmp_b,
    output logic [WIDTH-1:0] res,
    output logic             eq
);

    always_comb begin
        res = sub ? (lhs - rhs) : (lhs + rhs);
        eq  = (cmp_a == cmp_b);
    end

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int NREG   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halt
);

    localparam int RAW = $clog2(NREG);
    localparam int NRD = 3;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   pc_q;
    logic [INSN_W-1:0]   ir_q;
    logic [DATA_W-1:0]   opa_q, opb_q, opc_q;
    logic [ADDR_W-1:0]   ea_q;

    dec_t                dec;
    logic [NRD-1:0][RAW-1:0]    rf_ra;
    logic [NRD-1:0][DATA_W-1:0] rf_rd;
    logic                rf_we;
    logic [DATA_W-1:0]   rf_wd;
    logic [DATA_W-1:0]   alu_res;
    logic                alu_eq;
    logic [ADDR_W-1:0]   ea_d;

    mc_decode u_dec (
        .ir  (ir_q),
        .dec (dec)
    );

    assign rf_ra[0] = RAW'(dec.ra);
    assign rf_ra[1] = RAW'(dec.rb);
    assign rf_ra[2] = RAW'(dec.rc);

    assign rf_we = (state_q == ST_EXEC) &&
                   ((dec.kind == K_LOAD) || (dec.kind == K_ADD) || (dec.kind == K_SUB));
    assign rf_wd = (dec.kind == K_LOAD) ? mem_rdata : alu_res;

    mc_regfile #(
        .NREG  (NREG),
        .WIDTH (DATA_W),
        .NRD   (NRD)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (RAW'(dec.ra)),
        .wd    (rf_wd),
        .ra    (rf_ra),
        .rd    (rf_rd)
    );

    mc_alu #(
        .WIDTH (DATA_W)
    ) u_alu (
        .lhs   (opb_q),
        .rhs   (opc_q),
        .sub   (dec.kind == K_SUB),
        .cmp_a (opa_q),
        .cmp_b (opb_q),
        .res   (alu_res),
        .eq    (alu_eq)
    );

    // Effective address: K alone (direct) or K plus the B register (indexed)
    assign ea_d = ADDR_W'(dec.k) + (dec.indexed ? rf_rd[1][ADDR_W-1:0] : '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = (dec.kind == K_BAD) ? ST_HALT : ST_EXEC;
            ST_EXEC:   state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            opc_q <= '0;
            ea_q  <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    ir_q <= mem_rdata[INSN_W-1:0];
                    pc_q <= pc_q + ADDR_W'(1);
                end
                ST_DECODE: begin
                    opa_q <= rf_rd[0];
                    opb_q <= rf_rd[1];
                    opc_q <= rf_rd[2];
                    ea_q  <= ea_d;
                end
                ST_EXEC: begin
                    if (dec.kind == K_JMP) begin
                        pc_q <= ADDR_W'(dec.k);
                    end else if ((dec.kind == K_BEQ) && alu_eq) begin
                        pc_q <= pc_q + ADDR_W'(signed'(dec.k));
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr  = (state_q == ST_EXEC) ? ea_q : pc_q;
        mem_wdata = opa_q;
        mem_we    = (state_q == ST_EXEC) && (dec.kind == K_STORE);
        halt      = (state_q == ST_HALT);
    end

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));               // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));   // R10
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && dec.kind == K_JMP) |=> (pc_q == ADDR_W'($past(dec.k)))); // R6
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && dec.ra == '0) |=> (opa_q == '0));       // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && $stable(pc_q)));                               // R9
    AST_NO_STORE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_we);                                               // R9
    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                             // R4

endmodule

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;

    localparam int MEM_N = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        halt;

    logic [31:0] mem     [MEM_N];
    logic [31:0] ref_mem [MEM_N];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    mc_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halt      (halt)
    );

    function automatic logic [31:0] enc(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [15:0] k);
        return {op, a, b, k};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_N; i++) mem[i] = 32'h0;
    endtask

    // Instruction-level model written from the requirements
    task automatic model_run(output int n_exec);
        logic [31:0] rf [32];
        logic [15:0] pc, k, ea;
        logic [31:0] ir;
        logic [5:0]  op;
        logic [4:0]  a, b;
        bit          stop;
        for (int i = 0; i < 32; i++) rf[i] = 32'h0;
        pc = 16'h0; n_exec = 0; stop = 0;
        while (!stop && n_exec < 5000) begin
            ir = ref_mem[pc[7:0]];
            pc = pc + 16'd1;
            op = ir[31:26]; a = ir[25:21]; b = ir[20:16]; k = ir[15:0];
            ea = k + ((b != 5'd0) ? rf[b][15:0] : 16'h0);
            case (op)
                6'd1: if (a != 5'd0) rf[a] = ref_mem[ea[7:0]];
                6'd2: ref_mem[ea[7:0]] = rf[a];
                6'd3, 6'd4: begin
                    if (k[15:5] != 11'd0) stop = 1;
                    else if (a != 5'd0)
                        rf[a] = (op == 6'd3) ? rf[b] + rf[k[4:0]] : rf[b] - rf[k[4:0]];
                end
                6'd5: pc = k;
                6'd6: if (rf[a] == rf[b]) pc = pc + k;
                default: stop = 1;
            endcase
            if (!stop) n_exec++;
        end
    endtask

    task automatic run_prog(string req);
        int          n_exp;
        int          cyc;
        logic [15:0] a_hold;
        rst_n = 1'b0;
        for (int i = 0; i < MEM_N; i++) ref_mem[i] = mem[i];
        model_run(n_exp);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(mem_addr == 16'h0 && !halt && !mem_we, "R1", "reset outputs",
              {halt, mem_we, 14'h0, mem_addr}, 32'h0);
        rst_n = 1'b1;
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halt || cyc > 20000) break;
        end
        check(cyc == 3 * n_exp + 2, "R2", "halt cycle", cyc, 3 * n_exp + 2);
        a_hold = mem_addr;
        repeat (4) begin
            @(negedge clk);
            check(halt && !mem_we && mem_addr == a_hold, "R9", "halt sticky",
                  {halt, mem_we, 14'h0, mem_addr}, {2'b10, 14'h0, a_hold});
        end
        for (int i = 0; i < MEM_N; i++)
            check(mem[i] == ref_mem[i], req, $sformatf("memory word %0d", i), mem[i], ref_mem[i]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int pc;
        void'($urandom(32'h5eed));

        // Two loads, add, store (R3, R4, R5)
        clear_mem();
        mem[100] = 32'h1234_5678; mem[101] = 32'h0FED_CBA9;
        mem[0] = enc(6'd1, 5'd1, 5'd0, 16'd100);
        mem[1] = enc(6'd1, 5'd2, 5'd0, 16'd101);
        mem[2] = enc(6'd3, 5'd3, 5'd1, 16'd2);
        mem[3] = enc(6'd2, 5'd3, 5'd0, 16'd102);
        run_prog("R5");
        check(mem[102] == 32'h1234_5678 + 32'h0FED_CBA9, "R5", "add result", mem[102], 32'h1234_5678 + 32'h0FED_CBA9);

        // Subtract with wrap (R5)
        clear_mem();
        mem[100] = 32'd5; mem[101] = 32'd7;
        mem[0] = enc(6'd1, 5'd1, 5'd0, 16'd100);
        mem[1] = enc(6'd1, 5'd2, 5'd0, 16'd101);
        mem[2] = enc(6'd4, 5'd3, 5'd1, 16'd2);
        mem[3] = enc(6'd2, 5'd3, 5'd0, 16'd102);
        run_prog("R5");
        check(mem[102] == 32'hFFFF_FFFE, "R5", "sub wrap", mem[102], 32'hFFFF_FFFE);

        // Countdown loop with negative BEQ offset (R7)
        clear_mem();
        mem[100] = 32'd5; mem[101] = 32'd1;
        mem[0] = enc(6'd1, 5'd1, 5'd0, 16'd100);
        mem[1] = enc(6'd1, 5'd2, 5'd0, 16'd101);
        mem[2] = enc(6'd3, 5'd4, 5'd0, 16'd0);
        mem[3] = enc(6'd3, 5'd4, 5'd4, 16'd2);
        mem[4] = enc(6'd4, 5'd1, 5'd1, 16'd2);
        mem[5] = enc(6'd6, 5'd1, 5'd0, 16'd1);
        mem[6] = enc(6'd6, 5'd0, 5'd0, 16'hFFFC);
        mem[7] = enc(6'd2, 5'd4, 5'd0, 16'd110);
        mem[8] = enc(6'd2, 5'd1, 5'd0, 16'd111);
        run_prog("R7");
        check(mem[110] == 32'd5, "R7", "loop count", mem[110], 32'd5);
        check(mem[111] == 32'd0, "R7", "loop counter end", mem[111], 32'd0);

        // Jump over a store (R6)
        clear_mem();
        mem[100] = 32'd77; mem[120] = 32'hDEAD;
        mem[0] = enc(6'd5, 5'd0, 5'd0, 16'd3);
        mem[1] = enc(6'd2, 5'd0, 5'd0, 16'd120);
        mem[3] = enc(6'd1, 5'd1, 5'd0, 16'd100);
        mem[4] = enc(6'd2, 5'd1, 5'd0, 16'd121);
        run_prog("R6");
        check(mem[120] == 32'hDEAD, "R6", "skipped store", mem[120], 32'hDEAD);
        check(mem[121] == 32'd77, "R6", "jump target ran", mem[121], 32'd77);

        // Indexed and direct addressing (R3, R4)
        clear_mem();
        mem[130] = 32'd4; mem[104] = 32'hA5A5;
        mem[0] = enc(6'd1, 5'd5, 5'd0, 16'd130);
        mem[1] = enc(6'd1, 5'd6, 5'd5, 16'd100);
        mem[2] = enc(6'd2, 5'd6, 5'd5, 16'd140);
        mem[3] = enc(6'd2, 5'd6, 5'd0, 16'd141);
        run_prog("R3");
        check(mem[144] == 32'hA5A5, "R3", "indexed load/store", mem[144], 32'hA5A5);
        check(mem[141] == 32'hA5A5, "R4", "direct store", mem[141], 32'hA5A5);

        // Writes to register 0 ignored (R8)
        clear_mem();
        mem[100] = 32'd9; mem[150] = 32'd1; mem[151] = 32'd1;
        mem[0] = enc(6'd1, 5'd0, 5'd0, 16'd100);
        mem[1] = enc(6'd2, 5'd0, 5'd0, 16'd150);
        mem[2] = enc(6'd1, 5'd5, 5'd0, 16'd100);
        mem[3] = enc(6'd3, 5'd0, 5'd5, 16'd5);
        mem[4] = enc(6'd2, 5'd0, 5'd0, 16'd151);
        run_prog("R8");
        check(mem[150] == 32'd0, "R8", "r0 after load", mem[150], 32'd0);
        check(mem[151] == 32'd0, "R8", "r0 after add", mem[151], 32'd0);

        // Registers cleared by reset (R1)
        clear_mem();
        mem[170] = 32'd1;
        mem[0] = enc(6'd2, 5'd5, 5'd0, 16'd170);
        run_prog("R1");
        check(mem[170] == 32'd0, "R1", "register cleared", mem[170], 32'd0);

        // ADD with stray K bits halts (R9)
        clear_mem();
        mem[100] = 32'd3;
        mem[0] = enc(6'd1, 5'd1, 5'd0, 16'd100);
        mem[1] = enc(6'd3, 5'd2, 5'd1, 16'h0021);
        mem[2] = enc(6'd2, 5'd1, 5'd0, 16'd160);
        run_prog("R9");
        check(mem[160] == 32'd0, "R9", "no store after bad add", mem[160], 32'd0);

        // Opcode 7 at address 0 (R9)
        clear_mem();
        mem[0] = enc(6'd7, 5'd0, 5'd0, 16'd0);
        mem[1] = enc(6'd2, 5'd0, 5'd0, 16'd161);
        mem[161] = 32'd2;
        run_prog("R9");
        check(mem[161] == 32'd2, "R9", "opcode 7 halts", mem[161], 32'd2);

        // Opcode 63 after one store (R9)
        clear_mem();
        mem[162] = 32'd4;
        mem[0] = enc(6'd2, 5'd0, 5'd0, 16'd162);
        mem[1] = enc(6'd63, 5'd1, 5'd1, 16'hFFFF);
        run_prog("R9");
        check(mem[162] == 32'd0, "R9", "store before opcode 63", mem[162], 32'd0);

        // Random ALU/branch/store programs (R5, R7, R4)
        for (int t = 0; t < 6; t++) begin
            clear_mem();
            for (int i = 128; i < 136; i++) mem[i] = $urandom;
            pc = 0;
            for (int r = 1; r < 8; r++) begin
                mem[pc] = enc(6'd1, 5'(r), 5'd0, 16'(128 + r)); pc++;
            end
            for (int j = 0; j < 18; j++) begin
                case ($urandom % 4)
                    0, 1: mem[pc] = enc((($urandom % 2) == 0) ? 6'd3 : 6'd4, 5'($urandom % 8),
                                        5'($urandom % 8), 16'($urandom % 8));
                    2:    mem[pc] = enc(6'd6, 5'($urandom % 8), 5'($urandom % 8), 16'(1 + $urandom % 2));
                    default: mem[pc] = enc(6'd2, 5'($urandom % 8), 5'd0, 16'(200 + $urandom % 16));
                endcase
                pc++;
            end
            for (int r = 1; r < 8; r++) begin
                mem[pc] = enc(6'd2, 5'(r), 5'd0, 16'(240 + r)); pc++;
            end
            run_prog("R5");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule